// File: doc/BRIEF.md
# BCH Error Location Mapper

This block turns the raw bit-error locations that a BCH locator reports for one 512-byte sector into concrete correction commands. Locations are counted backwards from the far end of the codeword. The codeword covers the 512 data bytes plus the ECC bytes that take part in the code. With the 8-bit scheme that is 13 of its 14 ECC bytes, because one byte is reserved. With the 16-bit scheme it is all 26 ECC bytes.

A correction pass begins with a start pulse. The pulse carries the scheme, the number of locations to expect, the ECC bytes computed from the read data, and the ECC bytes stored in the spare area. A sector whose computed ECC is all zero is clean. A sector whose stored ECC is all 0xFF is erased. Such a sector, or one with no errors reported, finishes at once with nothing to correct. In every other case the block takes one location per cycle on a valid/ready handshake. Each location becomes a correction command that names a region (data or ECC), a byte offset in that region, and a one-hot bit mask, or it is marked invalid. After the last location, a done pulse reports how many corrections were issued and whether any location was invalid.

Top module: `errloc_mapper`

## Requirements
- R1: After reset, loc_ready_o, busy_o, cmd_valid_o, done_o, done_count_o and done_fail_o are all 0.
- R2: A start while idle whose computed ECC bytes are all 0x00 finishes with done_o high in the cycle after the start edge, with done_count_o = 0 and done_fail_o = 0, and loc_ready_o never rises. Byte k is bits [8k+7:8k] of calc_ecc_i. Only bytes 0..13 are checked when scheme_i = 0 (8-bit scheme), and bytes 0..25 when scheme_i = 1 (16-bit scheme).
- R3: A start whose stored ECC bytes (same byte numbering and per-scheme byte range as R2, on stored_ecc_i) are all 0xFF finishes the same way as R2.
- R4: A start with err_count_i = 0 finishes the same way as R2.
- R5: For a location L, the codeword limit M is 525 when scheme_i = 0 and 538 when scheme_i = 1. The byte position is P = M - 1 - (L >> 3).
- R6: If P < 512, the command has cmd_region_o = 0 (data) and cmd_offset_o = P.
- R7: If 512 <= P < M, the command has cmd_region_o = 1 (ECC) and cmd_offset_o = P - 512.
- R8: A location with (L >> 3) >= M is invalid. It issues no command and makes done_fail_o = 1 at the end of the pass.
- R9: cmd_mask_o equals 1 << (L mod 8).
- R10: While busy, loc_ready_o is 1 and one location is taken per clock. The command for a location accepted at a clock edge is valid only during the cycle after that edge. No command appears without an accepted location.
- R11: done_o pulses in the cycle after the edge that accepts the last of err_count_i locations. done_count_o is the number of commands issued in the pass, and busy_o falls in that same cycle.
- R12: start_i is ignored while busy. The pass length, the scheme and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass (taken only when idle) |
| scheme_i | input | 1 | 0 = 8-bit scheme, 1 = 16-bit scheme |
| err_count_i | input | 5 | Number of locations in the pass |
| calc_ecc_i | input | 208 | Computed ECC bytes, byte k at [8k+7:8k] |
| stored_ecc_i | input | 208 | Stored ECC bytes, byte k at [8k+7:8k] |
| loc_valid_i | input | 1 | Location present |
| loc_i | input | 13 | Bit-error location |
| loc_ready_o | output | 1 | Location accepted this cycle when valid |
| busy_o | output | 1 | Pass in progress |
| cmd_valid_o | output | 1 | Correction command present |
| cmd_region_o | output | 1 | 0 = data area, 1 = ECC area |
| cmd_offset_o | output | 10 | Byte offset within the region |
| cmd_mask_o | output | 8 | One-hot bit mask |
| done_o | output | 1 | End-of-pass pulse |
| done_count_o | output | 5 | Corrections issued in the pass |
| done_fail_o | output | 1 | An invalid location was seen |

## Verification
Every result of this block arrives exactly one clock after its cause. A command follows the edge that accepts its location, and the done pulse follows either the start edge of a skipped sector or the edge that accepts the last location. The bench drives its inputs on falling edges. After each rising edge it samples at the next falling edge, which is the single cycle in which each command or done pulse is due. Between locations it leaves random idle gaps and checks that nothing is issued during them.

// File: rtl/errloc_pkg.sv
package errloc_pkg;
    localparam int SECTOR_BYTES  = 512;
    localparam int ECC8_BYTES    = 14;
    localparam int ECC16_BYTES   = 26;
    localparam int MAX_ECC_BYTES = ECC16_BYTES;
    localparam int LOC_W         = 13;
    localparam int CNT_W         = 5;
    localparam int POS_W         = $clog2(SECTOR_BYTES + MAX_ECC_BYTES);

    typedef enum logic { SCH_BCH8 = 1'b0, SCH_BCH16 = 1'b1 } scheme_e;
    typedef enum logic { RGN_DATA = 1'b0, RGN_ECC = 1'b1 } region_e;
    typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } state_e;

    typedef struct packed {
        region_e          region;
        logic [POS_W-1:0] offset;
        logic [7:0]       mask;
    } fix_cmd_t;

    // ECC bytes that the sector check must inspect for a scheme
    function automatic int scan_bytes(scheme_e s);
        return (s == SCH_BCH16) ? ECC16_BYTES : ECC8_BYTES;
    endfunction

    // codeword length in bytes; the 8-bit scheme drops its reserved byte
    function automatic int code_limit(scheme_e s);
        return (s == SCH_BCH16) ? SECTOR_BYTES + ECC16_BYTES
                                : SECTOR_BYTES + ECC8_BYTES - 1;
    endfunction
endpackage

// File: rtl/errloc_scan.sv
module errloc_scan
    import errloc_pkg::*;
#(
    parameter int NBYTES = MAX_ECC_BYTES
) (
    input  scheme_e             scheme_i,
    input  logic [8*NBYTES-1:0] calc_i,
    input  logic [8*NBYTES-1:0] stored_i,
    output logic                clean_o,
    output logic                erased_o
);
    localparam int CW = $clog2(NBYTES + 1);

    logic [CW-1:0]     live_bytes;
    logic [NBYTES-1:0] zero_ok;
    logic [NBYTES-1:0] ff_ok;

    assign live_bytes = CW'(scan_bytes(scheme_i));

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign zero_ok[i] = (CW'(i) >= live_bytes) || (calc_i[8*i +: 8] == 8'h00);
        assign ff_ok[i]   = (CW'(i) >= live_bytes) || (stored_i[8*i +: 8] == 8'hFF);
    end

    assign clean_o  = &zero_ok;
    assign erased_o = &ff_ok;
endmodule

// File: rtl/errloc_decode.sv
module errloc_decode
    import errloc_pkg::*;
#(
    parameter int LW = LOC_W,
    parameter int PW = POS_W
) (
    input  scheme_e          scheme_i,
    input  logic [LW-1:0]    loc_i,
    output logic             ok_o,
    output fix_cmd_t         cmd_o
);
    localparam int WIDE = (LW - 3 > PW + 1) ? LW - 3 : PW + 1;

    logic [WIDE-1:0] limit;
    logic [WIDE-1:0] idx;
    logic [WIDE-1:0] pos;
    logic            in_data;

    always_comb begin
        limit   = WIDE'(code_limit(scheme_i));
        idx     = WIDE'(loc_i[LW-1:3]);
        ok_o    = idx < limit;
        pos     = limit - idx - WIDE'(1);
        in_data = pos < WIDE'(SECTOR_BYTES);
        cmd_o.region = in_data ? RGN_DATA : RGN_ECC;
        cmd_o.offset = in_data ? PW'(pos) : PW'(pos - WIDE'(SECTOR_BYTES));
        cmd_o.mask   = 8'd1 << loc_i[2:0];
    end
endmodule

// File: rtl/errloc_seq.sv
module errloc_seq
    import errloc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  scheme_e       scheme_i,
    input  logic [CW-1:0] count_i,
    input  logic          skip_i,
    input  logic          loc_valid_i,
    input  logic          dec_ok_i,
    input  fix_cmd_t      dec_cmd_i,
    output scheme_e       scheme_o,
    output logic          ready_o,
    output logic          cmd_valid_o,
    output fix_cmd_t      cmd_o,
    output logic          done_o,
    output logic [CW-1:0] done_count_o,
    output logic          done_fail_o
);
    state_e        state;
    scheme_e       scheme_q;
    logic [CW-1:0] remain;
    logic [CW-1:0] fixed;
    logic          failed;
    logic          accept;

    assign ready_o  = (state == ST_RUN);
    assign accept   = loc_valid_i && ready_o;
    assign scheme_o = scheme_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            scheme_q     <= SCH_BCH8;
            remain       <= '0;
            fixed        <= '0;
            failed       <= 1'b0;
            cmd_valid_o  <= 1'b0;
            cmd_o        <= '0;
            done_o       <= 1'b0;
            done_count_o <= '0;
            done_fail_o  <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            done_o      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        scheme_q <= scheme_i;
                        fixed    <= '0;
                        failed   <= 1'b0;
                        if (skip_i || count_i == '0) begin
                            done_o       <= 1'b1;
                            done_count_o <= '0;
                            done_fail_o  <= 1'b0;
                        end else begin
                            remain <= count_i;
                            state  <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (accept) begin
                        if (dec_ok_i) begin
                            cmd_valid_o <= 1'b1;
                            cmd_o       <= dec_cmd_i;
                            fixed       <= fixed + CW'(1);
                        end else begin
                            failed <= 1'b1;
                        end
                        remain <= remain - CW'(1);
                        if (remain == CW'(1)) begin
                            done_o       <= 1'b1;
                            done_count_o <= fixed + CW'(dec_ok_i);
                            done_fail_o  <= failed || !dec_ok_i;
                            state        <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_cmd_needs_accept_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> $past(accept));

    p_done_has_cause_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(accept) || $past(start_i && state == ST_IDLE)));

    p_count_bounded_r11: assert property (@(posedge clk) disable iff (rst)
        accept |-> (remain != '0));

    p_scheme_held_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state == ST_RUN)) |-> $stable(scheme_q));
endmodule

// File: rtl/errloc_mapper.sv
module errloc_mapper
    import errloc_pkg::*;
#(
    parameter int NBYTES = MAX_ECC_BYTES,
    parameter int LW     = LOC_W,
    parameter int CW     = CNT_W,
    parameter int PW     = POS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                scheme_i,
    input  logic [CW-1:0]       err_count_i,
    input  logic [8*NBYTES-1:0] calc_ecc_i,
    input  logic [8*NBYTES-1:0] stored_ecc_i,
    input  logic                loc_valid_i,
    input  logic [LW-1:0]       loc_i,
    output logic                loc_ready_o,
    output logic                busy_o,
    output logic                cmd_valid_o,
    output logic                cmd_region_o,
    output logic [PW-1:0]       cmd_offset_o,
    output logic [7:0]          cmd_mask_o,
    output logic                done_o,
    output logic [CW-1:0]       done_count_o,
    output logic                done_fail_o
);
    scheme_e  start_scheme;
    scheme_e  run_scheme;
    logic     clean;
    logic     erased;
    logic     dec_ok;
    fix_cmd_t dec_cmd;
    fix_cmd_t cmd;

    assign start_scheme = scheme_e'(scheme_i);

    errloc_scan #(.NBYTES(NBYTES)) u_scan (
        .scheme_i (start_scheme),
        .calc_i   (calc_ecc_i),
        .stored_i (stored_ecc_i),
        .clean_o  (clean),
        .erased_o (erased)
    );

    errloc_decode #(.LW(LW), .PW(PW)) u_decode (
        .scheme_i (run_scheme),
        .loc_i    (loc_i),
        .ok_o     (dec_ok),
        .cmd_o    (dec_cmd)
    );

    errloc_seq #(.CW(CW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .scheme_i     (start_scheme),
        .count_i      (err_count_i),
        .skip_i       (clean || erased),
        .loc_valid_i  (loc_valid_i),
        .dec_ok_i     (dec_ok),
        .dec_cmd_i    (dec_cmd),
        .scheme_o     (run_scheme),
        .ready_o      (loc_ready_o),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_o        (cmd),
        .done_o       (done_o),
        .done_count_o (done_count_o),
        .done_fail_o  (done_fail_o)
    );

    assign busy_o       = loc_ready_o;
    assign cmd_region_o = cmd.region;
    assign cmd_offset_o = cmd.offset;
    assign cmd_mask_o   = cmd.mask;

    p_mask_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> $onehot(cmd_mask_o));

    p_data_offset_range_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_region_o == RGN_DATA) |-> (int'(cmd_offset_o) < SECTOR_BYTES));

    p_ecc_offset_range_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_region_o == RGN_ECC)
            |-> (int'(cmd_offset_o) < code_limit(run_scheme) - SECTOR_BYTES));

    p_skip_no_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && done_count_o == '0 && !done_fail_o && $past(!loc_ready_o)) |-> !loc_ready_o);
endmodule

// File: tb/errloc_mapper_bench.sv
module errloc_mapper_bench;
    localparam int NB = 26;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          scheme_i = 1'b0;
    logic [4:0]    err_count_i = '0;
    logic [8*NB-1:0] calc_ecc_i = '0;
    logic [8*NB-1:0] stored_ecc_i = '0;
    logic          loc_valid_i = 1'b0;
    logic [12:0]   loc_i = '0;
    logic          loc_ready_o, busy_o, cmd_valid_o, cmd_region_o;
    logic [9:0]    cmd_offset_o;
    logic [7:0]    cmd_mask_o;
    logic          done_o, done_fail_o;
    logic [4:0]    done_count_o;

    int checks = 0;
    int errors = 0;
    int locs [32];

    always #10 clk = ~clk;

    errloc_mapper u_errloc_mapper (
        .clk, .rst, .start_i, .scheme_i, .err_count_i, .calc_ecc_i, .stored_ecc_i,
        .loc_valid_i, .loc_i, .loc_ready_o, .busy_o, .cmd_valid_o, .cmd_region_o,
        .cmd_offset_o, .cmd_mask_o, .done_o, .done_count_o, .done_fail_o
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int limit_of(input bit sch);
        return sch ? 538 : 525;
    endfunction

    function automatic bit loc_ok(input bit sch, input int loc);
        return (loc >> 3) < limit_of(sch);
    endfunction

    function automatic int exp_pos(input bit sch, input int loc);
        return limit_of(sch) - 1 - (loc >> 3);
    endfunction

    function automatic int exp_region(input bit sch, input int loc);
        return (exp_pos(sch, loc) < 512) ? 0 : 1;
    endfunction

    function automatic int exp_offset(input bit sch, input int loc);
        int p = exp_pos(sch, loc);
        return (p < 512) ? p : p - 512;
    endfunction

    // start a pass that is expected to be skipped
    task automatic skip_pass(input bit sch, input int n, input string req);
        @(negedge clk);
        start_i = 1'b1; scheme_i = sch; err_count_i = 5'(n);
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b1, {req, " done"}, int'(done_o), 1);
        chk(done_count_o == 5'd0 && !done_fail_o, {req, " count"}, int'(done_count_o), 0);
        chk(loc_ready_o == 1'b0, {req, " ready"}, int'(loc_ready_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, {req, " idle"}, int'(done_o), 0);
    endtask

    // full pass over locs[0..n-1]; stray_start injects a start while busy
    task automatic run_pass(input bit sch, input int n, input bit gaps, input bit stray_start);
        int good = 0;
        bit bad = 1'b0;
        @(negedge clk);
        start_i = 1'b1; scheme_i = sch; err_count_i = 5'(n);
        calc_ecc_i = {NB{8'h5A}}; stored_ecc_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && loc_ready_o && !done_o, "R10 busy after start", int'(busy_o), 1);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                if (stray_start) begin
                    start_i = 1'b1; scheme_i = !sch; err_count_i = 5'd0;
                end
                @(negedge clk);
                start_i = 1'b0; scheme_i = sch;
                chk(!cmd_valid_o && !done_o, "R12 gap/stray start no output", int'(cmd_valid_o), 0);
            end
            loc_valid_i = 1'b1; loc_i = 13'(locs[i]);
            @(negedge clk);
            loc_valid_i = 1'b0;
            if (loc_ok(sch, locs[i])) begin
                good++;
                chk(cmd_valid_o == 1'b1, "R10 cmd after accept", int'(cmd_valid_o), 1);
                chk(int'(cmd_region_o) == exp_region(sch, locs[i]), "R6/R7 region R5",
                    int'(cmd_region_o), exp_region(sch, locs[i]));
                chk(int'(cmd_offset_o) == exp_offset(sch, locs[i]),
                    (exp_region(sch, locs[i]) == 0) ? "R6 offset" : "R7 offset",
                    int'(cmd_offset_o), exp_offset(sch, locs[i]));
                chk(cmd_mask_o == 8'(1 << (locs[i] % 8)), "R9 mask",
                    int'(cmd_mask_o), 1 << (locs[i] % 8));
            end else begin
                bad = 1'b1;
                chk(cmd_valid_o == 1'b0, "R8 invalid no cmd", int'(cmd_valid_o), 0);
            end
            if (i == n - 1) begin
                chk(done_o == 1'b1, "R11 done", int'(done_o), 1);
                chk(int'(done_count_o) == good, "R11 count", int'(done_count_o), good);
                chk(done_fail_o == bad, "R8 fail flag", int'(done_fail_o), int'(bad));
                chk(busy_o == 1'b0, "R11 busy low", int'(busy_o), 0);
            end else begin
                chk(done_o == 1'b0, "R11 early done", int'(done_o), 0);
            end
        end
        @(negedge clk);
        chk(!done_o && !cmd_valid_o, "R11 single done", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!loc_ready_o && !busy_o && !cmd_valid_o && !done_o && done_count_o == 0 && !done_fail_o,
            "R1 reset state", int'(busy_o), 0);

        // R2: clean, checked bytes only; higher bytes ignored for 8-bit scheme
        calc_ecc_i = {NB{8'h33}};
        calc_ecc_i[8*14-1:0] = '0;
        stored_ecc_i = '0;
        skip_pass(1'b0, 4, "R2 clean 8-bit");
        calc_ecc_i = '0;
        skip_pass(1'b1, 7, "R2 clean 16-bit");
        // R3: erased
        calc_ecc_i = {NB{8'h11}};
        stored_ecc_i = '0;
        stored_ecc_i[8*14-1:0] = {14{8'hFF}};
        skip_pass(1'b0, 9, "R3 erased 8-bit");
        stored_ecc_i = {NB{8'hFF}};
        skip_pass(1'b1, 3, "R3 erased 16-bit");
        // R4: zero count
        stored_ecc_i = '0;
        skip_pass(1'b1, 0, "R4 zero count");

        // R2 negative: 16-bit scheme sees a nonzero byte 20
        @(negedge clk);
        calc_ecc_i = '0; calc_ecc_i[8*20 +: 8] = 8'h01; stored_ecc_i = '0;
        start_i = 1'b1; scheme_i = 1'b1; err_count_i = 5'd1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 byte 20 counts for 16-bit", int'(busy_o), 1);
        loc_valid_i = 1'b1; loc_i = 13'd0;
        @(negedge clk);
        loc_valid_i = 1'b0;
        chk(cmd_valid_o && cmd_region_o && cmd_offset_o == 10'd25, "R7 last ecc byte 16-bit",
            int'(cmd_offset_o), 25);

        // directed boundaries, both schemes
        for (int s = 0; s < 2; s++) begin
            int m = limit_of(1'(s));
            locs[0] = 0;
            locs[1] = 8 * (m - 512) + 7;
            locs[2] = 8 * (m - 513) + 3;
            locs[3] = 8 * (m - 1) + 5;
            locs[4] = 8 * m;
            locs[5] = 8191;
            locs[6] = 8 * (m - 1);
            run_pass(1'(s), 7, 1'b0, 1'b0);
        end

        // random passes with gaps and stray starts
        for (int p = 0; p < 40; p++) begin
            bit sch = 1'($urandom_range(0, 1));
            int n = $urandom_range(1, 16);
            for (int i = 0; i < n; i++)
                locs[i] = (p % 4 == 0) ? $urandom_range(0, 8191)
                                       : $urandom_range(0, 8 * (limit_of(sch) + 4) - 1);
            run_pass(sch, n, 1'b1, 1'(p % 2));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule